// File: doc/BRIEF.md
# Performance Event Counter Unit

This block measures how often chosen hardware events happen and how many clock cycles go by. It holds six programmable event counters and one cycle counter that can count nothing but clocks. Each programmable counter is told which single event number to watch. Every cycle, the watched line of a vector of single-cycle event pulses is sampled, and the counter adds one when that line is high and the counter is allowed to run.

Software reaches the unit through a small register port with a word address, write data, a write strobe, a read strobe and a privilege flag. A select register names one programmable counter. The event-type and count registers then act on that counter only. Enable bits are changed through a pair of registers: one sets bits where the write data holds a one, the other clears them. Bit 31 of each belongs to the cycle counter. A user-enable bit decides whether unprivileged software may use the unit at all.

Top module: `perf_event_unit`

## Requirements
- R1: The port decodes a 3-bit word address: 0 control, 1 user enable, 2 select, 3 event type, 4 indirect count, 5 enable set, 6 enable clear, 7 cycle count. After reset every one of them reads as zero, and read data is zero whenever the read strobe is low.
- R2: Control bit 0 is the global enable and reads back in bit 0. While it is clear, no counter changes except through a clear or a write.
- R3: An event counter adds one in a cycle where the global enable, its own enable bit and the event line indexed by its event number are all high. It wraps from 0xFFFFFFFF to 0.
- R4: A write with control bit 1 set clears all six event counters. A write with control bit 2 set clears the cycle counter. Neither bit is stored: control reads back only bit 0. A clear takes priority over counting in the same cycle.
- R5: Select bits [4:0] hold a counter index, which reads back from address 2. Address 3 reads and writes the 8-bit event number of the selected counter in bits [7:0]. Address 4 reads and writes the selected counter's value.
- R6: Writing a 1 to bit x (0..5) of enable set turns event counter x on, and a 1 in bit 31 turns the cycle counter on. A 1 written to the same bits of enable clear turns them off. Zero bits leave state alone. Both addresses read back the enable mask in bits 0..5 and 31.
- R7: The cycle counter adds one every cycle that the global enable and its own bit 31 enable are set, and it reads at address 7. Its enable has no effect on event counting.
- R8: With a select index above 5, reads of addresses 3 and 4 return zero and writes to them change nothing. Event numbers of 32 or more never cause an increment.
- R9: User-enable bit 0 lets unprivileged accesses through. An unprivileged access while it is clear has its write dropped and its read return zero, and the access-error output is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_priv | input | 1 | High for a privileged access |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| acc_err | output | 1 | Pulses one cycle after a refused access |
| evt_in | input | 32 | Event pulses, indexed by event number |

## Verification
Read data is combinational, so the bench compares it in the same cycle as the read strobe, one time unit after driving the inputs. A write or an event pulse takes effect at the next rising edge. The reference model therefore advances once per edge, and the next read sees the new value. The access error is registered, and the bench compares it just after the edge that follows each access. Every read and every cycle is checked against that model, for directed corner cases and for seeded random traffic.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int DATA_W  = 32;
  localparam int TYPE_W  = 8;
  localparam int SEL_W   = 5;
  localparam int ADDR_W  = 3;
  localparam int CYC_BIT = 31;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_USER  = 3'd1,
    A_SEL   = 3'd2,
    A_TYPE  = 3'd3,
    A_CNT   = 3'd4,
    A_ENSET = 3'd5,
    A_ENCLR = 3'd6,
    A_CYC   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/perf_event_ctr.sv
module perf_event_ctr
  import perf_pkg::*;
#(
  parameter int NUM_EVT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              cnt_en,
  input  logic              clr,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic              type_we,
  input  logic [TYPE_W-1:0] type_wdata,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] cnt_wdata,
  output logic [TYPE_W-1:0] type_q,
  output logic [DATA_W-1:0] cnt_q
);
  logic              hit;
  logic              step;
  logic              cnt_ld;
  logic [DATA_W-1:0] cnt_d;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (type_q == TYPE_W'(i)) hit = evt_in[i];
    end
  end

  always_comb begin
    step   = glb_en && cnt_en && hit;
    cnt_ld = clr || cnt_we || step;
    if (clr)         cnt_d = '0;
    else if (cnt_we) cnt_d = cnt_wdata;
    else             cnt_d = cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (type_we) type_q <= type_wdata;
      if (cnt_ld)  cnt_q  <= cnt_d;
    end
  end

  // R3
  ev_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !cnt_we) |=> (cnt_q == $past(cnt_q) + 32'd1));
  // R2
  ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !clr && !cnt_we) |=> $stable(cnt_q));
  // R4
  ev_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/perf_cycle_ctr.sv
module perf_cycle_ctr
  import perf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glb_en,
  input  logic              cyc_en,
  input  logic              clr,
  output logic [DATA_W-1:0] cyc_q
);
  logic              run;
  logic              ld;
  logic [DATA_W-1:0] cyc_d;

  always_comb begin
    run   = glb_en && cyc_en;
    ld    = clr || run;
    cyc_d = clr ? '0 : cyc_q + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cyc_q <= '0;
    else if (ld) cyc_q <= cyc_d;
  end

  // R7
  cyc_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (cyc_q == $past(cyc_q) + 32'd1));
  // R4
  cyc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cyc_q == '0));
endmodule

// File: rtl/perf_reg_if.sv
module perf_reg_if
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               we,
  input  logic               rd,
  input  logic               priv,
  input  logic [TYPE_W-1:0]  sel_type,
  input  logic [DATA_W-1:0]  sel_cnt,
  input  logic [DATA_W-1:0]  cyc_cnt,
  output logic [DATA_W-1:0]  rdata,
  output logic               acc_err,
  output logic               glb_en,
  output logic [NUM_CTR-1:0] ev_en,
  output logic               cyc_en,
  output logic               ev_clr,
  output logic               cyc_clr,
  output logic [SEL_W-1:0]   sel,
  output logic               type_we,
  output logic               cnt_we
);
  logic               allowed, wr_ok, rd_ok, sel_ok;
  logic               user_q, user_d, glb_d, cyc_en_d, err_d;
  logic [SEL_W-1:0]   sel_d;
  logic [NUM_CTR-1:0] ev_en_d;
  logic [DATA_W-1:0]  mask;
  logic [DATA_W-1:0]  mux;

  always_comb begin
    allowed = priv || user_q;
    wr_ok   = we && allowed;
    rd_ok   = rd && allowed;
    sel_ok  = (sel < SEL_W'(NUM_CTR));
    err_d   = (we || rd) && !allowed;
    ev_clr  = wr_ok && (addr == A_CTRL) && wdata[1];
    cyc_clr = wr_ok && (addr == A_CTRL) && wdata[2];
    type_we = wr_ok && (addr == A_TYPE) && sel_ok;
    cnt_we  = wr_ok && (addr == A_CNT)  && sel_ok;
  end

  always_comb begin
    glb_d    = glb_en;
    user_d   = user_q;
    sel_d    = sel;
    ev_en_d  = ev_en;
    cyc_en_d = cyc_en;
    if (wr_ok) begin
      case (addr)
        A_CTRL:  glb_d  = wdata[0];
        A_USER:  user_d = wdata[0];
        A_SEL:   sel_d  = wdata[SEL_W-1:0];
        A_ENSET: begin
          ev_en_d  = ev_en | wdata[NUM_CTR-1:0];
          cyc_en_d = cyc_en | wdata[CYC_BIT];
        end
        A_ENCLR: begin
          ev_en_d  = ev_en & ~wdata[NUM_CTR-1:0];
          cyc_en_d = cyc_en & ~wdata[CYC_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en  <= 1'b0;
      user_q  <= 1'b0;
      sel     <= '0;
      ev_en   <= '0;
      cyc_en  <= 1'b0;
      acc_err <= 1'b0;
    end else begin
      acc_err <= err_d;
      if (wr_ok) begin
        glb_en <= glb_d;
        user_q <= user_d;
        sel    <= sel_d;
        ev_en  <= ev_en_d;
        cyc_en <= cyc_en_d;
      end
    end
  end

  always_comb begin
    mask                 = '0;
    mask[NUM_CTR-1:0]    = ev_en;
    mask[CYC_BIT]        = cyc_en;
    case (addr)
      A_CTRL:          mux = {{(DATA_W-1){1'b0}}, glb_en};
      A_USER:          mux = {{(DATA_W-1){1'b0}}, user_q};
      A_SEL:           mux = {{(DATA_W-SEL_W){1'b0}}, sel};
      A_TYPE:          mux = {{(DATA_W-TYPE_W){1'b0}}, sel_type};
      A_CNT:           mux = sel_cnt;
      A_ENSET, A_ENCLR: mux = mask;
      default:         mux = cyc_cnt;
    endcase
    rdata = rd_ok ? mux : '0;
  end

  // R9
  denied_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((we || rd) && !allowed) |=> acc_err);
  // R9
  denied_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !allowed) |=> ($stable(glb_en) && $stable(ev_en) && $stable(cyc_en)
                          && $stable(sel) && $stable(user_q)));
  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_ENSET) |=>
      ((ev_en & $past(wdata[NUM_CTR-1:0])) == $past(wdata[NUM_CTR-1:0])));
  // R6
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && addr == A_ENCLR) |=> ((ev_en & $past(wdata[NUM_CTR-1:0])) == '0));
endmodule

// File: rtl/perf_event_unit.sv
module perf_event_unit
  import perf_pkg::*;
#(
  parameter int NUM_CTR = 6,
  parameter int NUM_EVT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               reg_we,
  input  logic               reg_rd,
  input  logic               reg_priv,
  output logic [31:0]        reg_rdata,
  output logic               acc_err,
  input  logic [NUM_EVT-1:0] evt_in
);
  logic               glb_en, cyc_en, ev_clr, cyc_clr, type_we, cnt_we;
  logic [NUM_CTR-1:0] ev_en;
  logic [SEL_W-1:0]   sel;
  logic [TYPE_W-1:0]  sel_type;
  logic [DATA_W-1:0]  sel_cnt, cyc_cnt;
  logic [TYPE_W-1:0]  type_q [NUM_CTR];
  logic [DATA_W-1:0]  cnt_q  [NUM_CTR];

  perf_reg_if #(.NUM_CTR(NUM_CTR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
    .we(reg_we), .rd(reg_rd), .priv(reg_priv),
    .sel_type(sel_type), .sel_cnt(sel_cnt), .cyc_cnt(cyc_cnt),
    .rdata(reg_rdata), .acc_err(acc_err), .glb_en(glb_en), .ev_en(ev_en),
    .cyc_en(cyc_en), .ev_clr(ev_clr), .cyc_clr(cyc_clr), .sel(sel),
    .type_we(type_we), .cnt_we(cnt_we)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    perf_event_ctr #(.NUM_EVT(NUM_EVT)) u_ctr (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cnt_en(ev_en[g]),
      .clr(ev_clr), .evt_in(evt_in),
      .type_we(type_we && (sel == SEL_W'(g))), .type_wdata(reg_wdata[TYPE_W-1:0]),
      .cnt_we(cnt_we && (sel == SEL_W'(g))), .cnt_wdata(reg_wdata),
      .type_q(type_q[g]), .cnt_q(cnt_q[g])
    );
  end

  always_comb begin
    sel_type = '0;
    sel_cnt  = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel == SEL_W'(i)) begin
        sel_type = type_q[i];
        sel_cnt  = cnt_q[i];
      end
    end
  end

  perf_cycle_ctr u_cyc (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .cyc_en(cyc_en),
    .clr(cyc_clr), .cyc_q(cyc_cnt)
  );

  // R8
  oor_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (reg_addr == A_CNT || reg_addr == A_TYPE) && sel >= SEL_W'(NUM_CTR))
      |-> (reg_rdata == '0));
  // R1
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/test_perf_event_unit.sv
`timescale 1ns/1ps
module test_perf_event_unit;
  localparam int NC = 6;
  localparam int NE = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic          reg_we, reg_rd, reg_priv, acc_err;
  logic [NE-1:0] evt_in;

  always #2 clk = ~clk;

  perf_event_unit #(.NUM_CTR(NC), .NUM_EVT(NE)) i_perf_event_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rd(reg_rd), .reg_priv(reg_priv),
    .reg_rdata(reg_rdata), .acc_err(acc_err), .evt_in(evt_in)
  );

  logic [31:0] m_cnt [NC];
  logic [7:0]  m_type [NC];
  logic [NC-1:0] m_en;
  logic        m_cyc_en, m_glb, m_user;
  logic [4:0]  m_sel;
  logic [31:0] m_cyc;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic logic [31:0] model_read(input logic [2:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      3'd0: r[0] = m_glb;
      3'd1: r[0] = m_user;
      3'd2: r[4:0] = m_sel;
      3'd3: if (m_sel < NC) r[7:0] = m_type[m_sel];
      3'd4: if (m_sel < NC) r = m_cnt[m_sel];
      3'd5, 3'd6: begin r[NC-1:0] = m_en; r[31] = m_cyc_en; end
      default: r = m_cyc;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R9";
      3'd2, 3'd3, 3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One bus cycle; entered and left just after a falling edge.
  task automatic cyc(input logic we_i, input logic rd_i, input logic [2:0] a,
                     input logic [31:0] wd, input logic pr, input logic [NE-1:0] ev,
                     input string tag);
    logic denied, w;
    reg_we = we_i; reg_rd = rd_i; reg_addr = a; reg_wdata = wd;
    reg_priv = pr; evt_in = ev;
    #1;
    denied = !pr && !m_user;
    w = we_i && !denied;
    if (rd_i) chk((tag == "") ? tag_of(a) : tag, reg_rdata, denied ? 32'h0 : model_read(a));
    for (int i = 0; i < NC; i++) begin
      if (w && a == 3'd0 && wd[1]) m_cnt[i] = '0;
      else if (w && a == 3'd4 && m_sel == 5'(i)) m_cnt[i] = wd;
      else if (m_glb && m_en[i] && m_type[i] < NE && ev[m_type[i][4:0]]) m_cnt[i]++;
    end
    if (w && a == 3'd0 && wd[2]) m_cyc = '0;
    else if (m_glb && m_cyc_en) m_cyc++;
    if (w && a == 3'd3 && m_sel < NC) m_type[m_sel] = wd[7:0];
    if (w) begin
      case (a)
        3'd0: m_glb = wd[0];
        3'd1: m_user = wd[0];
        3'd2: m_sel = wd[4:0];
        3'd5: begin m_en = m_en | wd[NC-1:0]; m_cyc_en = m_cyc_en | wd[31]; end
        3'd6: begin m_en = m_en & ~wd[NC-1:0]; m_cyc_en = m_cyc_en & ~wd[31]; end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk("R9", {31'b0, acc_err}, {31'b0, (we_i || rd_i) && denied});
    @(negedge clk); #0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b0, a, d, 1'b1, '0, "");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    cyc(1'b0, 1'b1, a, '0, 1'b1, '0, tag);
  endtask
  task automatic run(input int n, input logic [NE-1:0] ev);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 3'd0, '0, 1'b1, ev, "");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin m_cnt[i] = '0; m_type[i] = '0; end
    m_en = '0; m_cyc_en = 0; m_glb = 0; m_user = 0; m_sel = '0; m_cyc = '0;
    rst_n = 0; reg_we = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    reg_priv = 0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 8; a++) rd(3'(a), "R1");          // R1 reset values
    cyc(1'b0, 1'b0, 3'd3, '0, 1'b1, '0, "");
    chk("R1", reg_rdata, 32'h0);                           // R1 idle read data

    wr(3'd2, 0); wr(3'd3, 3);
    wr(3'd2, 1); wr(3'd3, 40);                             // R8 event number beyond lines
    wr(3'd5, 32'h8000_0003);
    run(5, '1);                                            // R2 nothing moves while off
    wr(3'd2, 0); rd(3'd4, "R2");
    wr(3'd0, 1);
    run(10, '1); run(4, 32'h0000_0008); run(4, 32'hFFFF_FFF7);
    wr(3'd2, 0); rd(3'd4, "R3"); rd(3'd3, "R5");
    wr(3'd2, 1); rd(3'd4, "R8");
    rd(3'd7, "R7");
    wr(3'd0, 0); run(6, '1); rd(3'd4, "R2"); rd(3'd7, "R2");
    wr(3'd2, 0); wr(3'd4, 32'hFFFF_FFFE); wr(3'd0, 1);
    run(3, '1); rd(3'd4, "R3");                            // R3 wrap through zero
    wr(3'd6, 32'h8000_0000); run(5, '1);
    rd(3'd7, "R7"); rd(3'd4, "R7");                        // R7 independence
    rd(3'd5, "R6"); rd(3'd6, "R6");
    wr(3'd5, 32'h0000_0004); rd(3'd6, "R6");
    wr(3'd2, 7); rd(3'd4, "R8"); rd(3'd3, "R8");
    wr(3'd4, 32'h1234); wr(3'd3, 9);
    wr(3'd2, 0); rd(3'd4, "R8"); rd(3'd3, "R8");
    wr(3'd5, 32'h8000_0000); run(3, '1);
    wr(3'd0, 32'h7); rd(3'd0, "R4"); rd(3'd4, "R4"); rd(3'd7, "R4");
    wr(3'd0, 32'h3); rd(3'd7, "R4");
    cyc(1'b1, 1'b0, 3'd2, 3, 1'b0, '0, "R9");              // R9 dropped write
    cyc(1'b0, 1'b1, 3'd2, '0, 1'b0, '0, "R9");
    rd(3'd2, "R9");
    wr(3'd1, 1);
    cyc(1'b0, 1'b1, 3'd2, '0, 1'b0, '0, "R9");
    cyc(1'b1, 1'b0, 3'd2, 4, 1'b0, '0, "R9");
    rd(3'd2, "R9");

    for (int n = 0; n < 6000; n++) begin
      logic [2:0] a;
      logic [31:0] d;
      int op;
      op = $urandom % 4;
      a = 3'($urandom % 8);
      d = $urandom;
      case (a)
        3'd0: d = {29'b0, ($urandom % 16 == 0), ($urandom % 16 == 0), ($urandom % 5 != 0)};
        3'd1: d = {31'b0, ($urandom % 3 != 0)};
        3'd2: d = 32'($urandom % 8);
        3'd3: d = 32'($urandom % 40);
        3'd4: d = ($urandom % 4 == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : d;
        default: ;
      endcase
      cyc(op == 1, op >= 2, a, d, ($urandom % 4 != 0), NE'($urandom), "");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule